// File: doc/BRIEF.md
# Register front end for a parallel key-search engine

This block is the CPU-facing register file of a brute-force key-search engine. Over an AXI4-Lite slave port the processor loads a 64-bit known plaintext, the matching 64-bit ciphertext and a 56-bit first key to try. The same port reads back the search progress and the key that produced the match. The engine itself sits outside the block. It sees the operands as plain level outputs and is controlled by two one-cycle command pulses: writing the low half of the first key launches a search, and writing its high half halts one.

The engine's progress key changes on every clock, but the CPU can only read it 32 bits at a time. To keep a split read coherent, a snapshot register tracks the live key until the low half is read. It then holds that value until the high half has been read. When the engine reports a match, the block captures the winning key, sets a sticky status bit and raises a single-cycle interrupt.

Top module: `keysrch_axil_regs`

## Requirements
- R1: After reset every register reads as zero, `start_o`, `stop_o`, `irq_o`, `bvalid_o` and `rvalid_o` are low, and `arready_o` is high.
- R2: A write is accepted in the clock where AW and W are both valid. `bvalid_o` then rises with `bresp_o` = 00 and stays high until `bready_i`. No further write is accepted (`awready_o`/`wready_o` low) while it is high.
- R3: A read is accepted in the clock where `arvalid_i` is high and no response is pending. `rvalid_o` then rises with `rresp_o` = 00 and `rdata_o` stays stable until `rready_i`. `arready_o` is low while `rvalid_o` is high.
- R4: Plaintext words sit at 0x00 (bits 31:0) and 0x04 (bits 63:32), and ciphertext words at 0x08 and 0x0C. Every write honours `wstrb_i`, where bit n enables data byte n. All four words read back what was written.
- R5: The first key has its bits 31:0 at 0x10 and bits 55:32 at 0x14. Bits 31:24 of 0x14 are never stored and read as zero. The high words of the current key (0x1C) and the found key (0x24) also read zero in bits 31:24.
- R6: A write accepted at 0x10 makes `start_o` high for exactly the one clock after acceptance. `start_key_o` already holds the new value in that clock.
- R7: A write accepted at 0x14 makes `stop_o` high for exactly the one clock after acceptance.
- R8: The current key reads bits 31:0 at 0x18 and bits 55:32 at 0x1C. While tracking, a read returns the engine key sampled one clock before acceptance. Reading 0x18 holds that value until 0x1C is read, so the two halves always belong to one sample.
- R9: On a rising edge of `found_i`, `irq_o` is high for exactly the next clock. `found_key_i` is captured and readable at 0x20/0x24, and bit 0 of 0x28 becomes 1. A start write clears that bit, unless a rising edge of `found_i` arrives in the same clock.
- R10: Reads from unused or unaligned addresses return zero with OKAY. Writes to read-only or unused addresses change no register and emit no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awaddr_i | input | AW | Write address |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Write byte enables |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| bresp_o | output | 2 | Write response (always OKAY) |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| araddr_i | input | AW | Read address |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| rdata_o | output | 32 | Read data |
| rresp_o | output | 2 | Read response (always OKAY) |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Read data ready |
| plain_o | output | BLK_W | Known plaintext to the engine |
| cipher_o | output | BLK_W | Target ciphertext to the engine |
| start_key_o | output | KEY_W | First key of the search |
| start_o | output | 1 | One-cycle launch command |
| stop_o | output | 1 | One-cycle halt command |
| cur_key_i | input | KEY_W | Engine progress key |
| found_i | input | 1 | Engine match flag (level) |
| found_key_i | input | KEY_W | Key that produced the match |
| irq_o | output | 1 | One-cycle match interrupt |

## Verification
The bench uses the default parameters: an 8-bit address, a 56-bit key and 64-bit blocks. With a key wider than one data word, the high key word carries unstored padding bits. It also means a carry out of the low word changes the high word. The engine stub counts by one from a first key just below a 32-bit boundary. Split reads of the progress key, with varied gaps between the halves, therefore straddle that carry, where an incoherent snapshot would show up. The stub's match target lies a few dozen keys past the first key, so the interrupt, the found-key capture and the status clear are all reached within a short run.

// File: rtl/keysrch_pkg.sv
package keysrch_pkg;

  localparam int unsigned REG_DW = 32;
  localparam int unsigned REG_BE = REG_DW / 8;

  // byte offsets
  localparam logic [7:0] OFS_PT     = 8'h00;
  localparam logic [7:0] OFS_CT     = 8'h08;
  localparam logic [7:0] OFS_SK_LO  = 8'h10;
  localparam logic [7:0] OFS_SK_HI  = 8'h14;
  localparam logic [7:0] OFS_CUR_LO = 8'h18;
  localparam logic [7:0] OFS_CUR_HI = 8'h1C;
  localparam logic [7:0] OFS_FK_LO  = 8'h20;
  localparam logic [7:0] OFS_FK_HI  = 8'h24;
  localparam logic [7:0] OFS_STAT   = 8'h28;

  typedef enum logic {CH_WAIT, CH_RUN} ch_state_e;
  typedef enum logic {SNAP_TRACK, SNAP_HOLD} snap_state_e;

  function automatic logic [REG_DW-1:0] strb_merge(
    input logic [REG_DW-1:0] old_w,
    input logic [REG_DW-1:0] new_w,
    input logic [REG_BE-1:0] be
  );
    logic [REG_DW-1:0] r;
    r = old_w;
    for (int b = 0; b < REG_BE; b++) begin
      if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/keysrch_wr_ch.sv
module keysrch_wr_ch
  import keysrch_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic awvalid_i,
  output logic awready_o,
  input  logic wvalid_i,
  output logic wready_o,
  output logic bvalid_o,
  input  logic bready_i,
  output logic we_o
);

  ch_state_e st_q;

  // AW and W are taken together in one beat
  assign awready_o = (st_q == CH_WAIT) && wvalid_i;
  assign wready_o  = (st_q == CH_WAIT) && awvalid_i;
  assign we_o      = (st_q == CH_WAIT) && awvalid_i && wvalid_i;
  assign bvalid_o  = (st_q == CH_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          st_q <= CH_WAIT;
    else if (we_o)                        st_q <= CH_RUN;
    else if (st_q == CH_RUN && bready_i)  st_q <= CH_WAIT;
  end

endmodule

// File: rtl/keysrch_rd_ch.sv
module keysrch_rd_ch
  import keysrch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  input  logic [REG_DW-1:0] mux_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              re_o
);

  ch_state_e         st_q;
  logic [REG_DW-1:0] data_q;

  assign arready_o = (st_q == CH_WAIT);
  assign re_o      = arready_o && arvalid_i;
  assign rvalid_o  = (st_q == CH_RUN);
  assign rdata_o   = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CH_WAIT;
      data_q <= '0;
    end else if (re_o) begin
      st_q   <= CH_RUN;
      data_q <= mux_i;
    end else if (st_q == CH_RUN && rready_i) begin
      st_q   <= CH_WAIT;
    end
  end

endmodule

// File: rtl/keysrch_snap.sv
module keysrch_snap
  import keysrch_pkg::*;
#(
  parameter int unsigned KW = 56
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [KW-1:0] live_i,
  input  logic          rd_lo_i,
  input  logic          rd_hi_i,
  output logic [KW-1:0] snap_o
);

  snap_state_e st_q;
  logic [KW-1:0] snap_q;

  assign snap_o = snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SNAP_TRACK;
      snap_q <= '0;
    end else begin
      if (st_q == SNAP_TRACK && !rd_lo_i) snap_q <= live_i;
      if (rd_lo_i)      st_q <= SNAP_HOLD;
      else if (rd_hi_i) st_q <= SNAP_TRACK;
    end
  end

endmodule

// File: rtl/keysrch_axil_regs.sv
module keysrch_axil_regs
  import keysrch_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned KEY_W = 56,
  parameter int unsigned BLK_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic [REG_BE-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [AW-1:0]     araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [REG_DW-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic [BLK_W-1:0]  plain_o,
  output logic [BLK_W-1:0]  cipher_o,
  output logic [KEY_W-1:0]  start_key_o,
  output logic              start_o,
  output logic              stop_o,
  input  logic [KEY_W-1:0]  cur_key_i,
  input  logic              found_i,
  input  logic [KEY_W-1:0]  found_key_i,
  output logic              irq_o
);

  localparam int unsigned BLK_WORDS = BLK_W / REG_DW;
  localparam int unsigned KEY_HI_W  = KEY_W - REG_DW;

  logic              we, re, rd_lo, rd_hi, found_rise;
  logic              sk_lo_wr, sk_hi_wr;
  logic [REG_DW-1:0] rd_mux;
  logic [REG_DW-1:0] pt_w [BLK_WORDS];
  logic [REG_DW-1:0] ct_w [BLK_WORDS];
  logic [KEY_W-1:0]  sk_q, fkey_q, snap;
  logic              flag_q, found_d_q, irq_q, start_q, stop_q;

  assign bresp_o = 2'b00;
  assign rresp_o = 2'b00;

  keysrch_wr_ch u_wr (
    .clk_i, .rst_ni, .awvalid_i, .awready_o, .wvalid_i, .wready_o,
    .bvalid_o, .bready_i, .we_o(we)
  );

  keysrch_rd_ch u_rd (
    .clk_i, .rst_ni, .arvalid_i, .arready_o, .rvalid_o, .rready_i,
    .mux_i(rd_mux), .rdata_o, .re_o(re)
  );

  assign rd_lo = re && (araddr_i == AW'(OFS_CUR_LO));
  assign rd_hi = re && (araddr_i == AW'(OFS_CUR_HI));

  keysrch_snap #(.KW(KEY_W)) u_snap (
    .clk_i, .rst_ni, .live_i(cur_key_i), .rd_lo_i(rd_lo), .rd_hi_i(rd_hi),
    .snap_o(snap)
  );

  // plaintext / ciphertext word registers
  for (genvar i = 0; i < BLK_WORDS; i++) begin : g_blk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pt_w[i] <= '0;
        ct_w[i] <= '0;
      end else if (we) begin
        if (awaddr_i == AW'(OFS_PT + 4 * i)) pt_w[i] <= strb_merge(pt_w[i], wdata_i, wstrb_i);
        if (awaddr_i == AW'(OFS_CT + 4 * i)) ct_w[i] <= strb_merge(ct_w[i], wdata_i, wstrb_i);
      end
    end
    assign plain_o[i*REG_DW +: REG_DW]  = pt_w[i];
    assign cipher_o[i*REG_DW +: REG_DW] = ct_w[i];
  end

  assign sk_lo_wr   = we && (awaddr_i == AW'(OFS_SK_LO));
  assign sk_hi_wr   = we && (awaddr_i == AW'(OFS_SK_HI));
  assign found_rise = found_i && !found_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sk_q      <= '0;
      fkey_q    <= '0;
      flag_q    <= 1'b0;
      found_d_q <= 1'b0;
      irq_q     <= 1'b0;
      start_q   <= 1'b0;
      stop_q    <= 1'b0;
    end else begin
      if (sk_lo_wr) sk_q[REG_DW-1:0] <= strb_merge(sk_q[REG_DW-1:0], wdata_i, wstrb_i);
      if (sk_hi_wr) sk_q[KEY_W-1:REG_DW] <=
          KEY_HI_W'(strb_merge(REG_DW'(sk_q[KEY_W-1:REG_DW]), wdata_i, wstrb_i));
      start_q   <= sk_lo_wr;
      stop_q    <= sk_hi_wr;
      found_d_q <= found_i;
      irq_q     <= found_rise;
      if (found_rise) fkey_q <= found_key_i;
      // set wins over a coincident clear
      if (found_rise)    flag_q <= 1'b1;
      else if (sk_lo_wr) flag_q <= 1'b0;
    end
  end

  assign start_key_o = sk_q;
  assign start_o     = start_q;
  assign stop_o      = stop_q;
  assign irq_o       = irq_q;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < BLK_WORDS; i++) begin
      if (araddr_i == AW'(OFS_PT + 4 * i)) rd_mux = pt_w[i];
      if (araddr_i == AW'(OFS_CT + 4 * i)) rd_mux = ct_w[i];
    end
    if (araddr_i == AW'(OFS_SK_LO))  rd_mux = sk_q[REG_DW-1:0];
    if (araddr_i == AW'(OFS_SK_HI))  rd_mux = REG_DW'(sk_q[KEY_W-1:REG_DW]);
    if (araddr_i == AW'(OFS_CUR_LO)) rd_mux = snap[REG_DW-1:0];
    if (araddr_i == AW'(OFS_CUR_HI)) rd_mux = REG_DW'(snap[KEY_W-1:REG_DW]);
    if (araddr_i == AW'(OFS_FK_LO))  rd_mux = fkey_q[REG_DW-1:0];
    if (araddr_i == AW'(OFS_FK_HI))  rd_mux = REG_DW'(fkey_q[KEY_W-1:REG_DW]);
    if (araddr_i == AW'(OFS_STAT))   rd_mux = REG_DW'(flag_q);
  end

endmodule

// File: rtl/keysrch_axil_chk.sv
module keysrch_axil_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        awready_o,
  input logic        bvalid_o,
  input logic        bready_i,
  input logic        arready_o,
  input logic        rvalid_o,
  input logic        rready_i,
  input logic [31:0] rdata_o,
  input logic        start_o,
  input logic        stop_o,
  input logic        found_i,
  input logic        irq_o
);

  // R2
  bresp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o && !bready_i |=> bvalid_o);

  // R2
  wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o |-> !awready_o);

  // R3
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o));

  // R3
  rd_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !arready_o);

  // R6
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  // R7
  stop_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);

  // R7
  cmd_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));

  // R9
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R9
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(found_i));

endmodule

bind keysrch_axil_regs keysrch_axil_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .awready_o(awready_o), .bvalid_o(bvalid_o),
  .bready_i(bready_i), .arready_o(arready_o), .rvalid_o(rvalid_o),
  .rready_i(rready_i), .rdata_o(rdata_o), .start_o(start_o), .stop_o(stop_o),
  .found_i(found_i), .irq_o(irq_o)
);

// File: tb/keysrch_axil_regs_tb_top.sv
`timescale 1ns/1ps
module keysrch_axil_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [63:0] plain, cipher;
  logic [55:0] start_key, cur, fkey_in, target;
  logic        start, stop, found, irq, run;

  int vectors = 0, errs = 0, irq_cnt = 0;

  always #2 clk = ~clk;

  keysrch_axil_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .awaddr_i(awaddr), .awvalid_i(awvalid), .awready_o(awready),
    .wdata_i(wdata), .wstrb_i(wstrb), .wvalid_i(wvalid), .wready_o(wready),
    .bresp_o(bresp), .bvalid_o(bvalid), .bready_i(bready),
    .araddr_i(araddr), .arvalid_i(arvalid), .arready_o(arready),
    .rdata_o(rdata), .rresp_o(rresp), .rvalid_o(rvalid), .rready_i(rready),
    .plain_o(plain), .cipher_o(cipher), .start_key_o(start_key),
    .start_o(start), .stop_o(stop), .cur_key_i(cur), .found_i(found),
    .found_key_i(fkey_in), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural engine stub: counts by one while running
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0; run <= 0; found <= 0; fkey_in <= '0;
    end else if (start) begin
      cur <= start_key; run <= 1; found <= 0;
    end else if (stop) begin
      run <= 0;
    end else if (run) begin
      if (cur == target) begin found <= 1; fkey_in <= cur; run <= 0; end
      else cur <= cur + 56'd1;
    end
  end

  // reference model, updated on each clock from the port values before the edge
  logic [63:0] m_pt, m_ct;
  logic [55:0] m_sk, m_fk, m_snap;
  logic        m_flag, m_fd, m_irq, m_start, m_stop, m_bv, m_rv, m_hold;
  logic [31:0] m_rdata;

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_pt[31:0];
      8'h04: return m_pt[63:32];
      8'h08: return m_ct[31:0];
      8'h0C: return m_ct[63:32];
      8'h10: return m_sk[31:0];
      8'h14: return {8'h0, m_sk[55:32]};
      8'h18: return m_snap[31:0];
      8'h1C: return {8'h0, m_snap[55:32]};
      8'h20: return m_fk[31:0];
      8'h24: return {8'h0, m_fk[55:32]};
      8'h28: return {31'h0, m_flag};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pt = '0; m_ct = '0; m_sk = '0; m_fk = '0; m_snap = '0; m_flag = 0; m_fd = 0;
      m_irq = 0; m_start = 0; m_stop = 0; m_bv = 0; m_rv = 0; m_hold = 0; m_rdata = '0;
    end else begin
      logic lo, hi;
      lo = 0; hi = 0;
      if (!m_rv && arvalid) begin
        m_rdata = m_read(araddr);
        lo = (araddr == 8'h18);
        hi = (araddr == 8'h1C);
        m_rv = 1;
      end else if (m_rv && rready) m_rv = 0;
      m_start = 0; m_stop = 0;
      if (!m_bv && awvalid && wvalid) begin
        m_bv = 1;
        case (awaddr)
          8'h00: m_pt[31:0]  = merge(m_pt[31:0], wdata, wstrb);
          8'h04: m_pt[63:32] = merge(m_pt[63:32], wdata, wstrb);
          8'h08: m_ct[31:0]  = merge(m_ct[31:0], wdata, wstrb);
          8'h0C: m_ct[63:32] = merge(m_ct[63:32], wdata, wstrb);
          8'h10: begin m_sk[31:0] = merge(m_sk[31:0], wdata, wstrb); m_start = 1; m_flag = 0; end
          8'h14: begin m_sk[55:32] = 24'(merge({8'h0, m_sk[55:32]}, wdata, wstrb)); m_stop = 1; end
          default: ;
        endcase
      end else if (m_bv && bready) m_bv = 0;
      m_irq = found && !m_fd;
      if (m_irq) begin m_fk = fkey_in; m_flag = 1; end
      m_fd = found;
      if (lo) m_hold = 1;
      else begin
        if (!m_hold) m_snap = cur;
        if (hi) m_hold = 0;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(start == m_start, "R6 start_o", 64'(start), 64'(m_start));
      chk(stop == m_stop, "R7 stop_o", 64'(stop), 64'(m_stop));
      chk(irq == m_irq, "R9 irq_o", 64'(irq), 64'(m_irq));
      chk(bvalid == m_bv && bresp == 2'b00, "R2 bvalid/bresp", {bresp, 1'b0, bvalid}, 64'(m_bv));
      chk(rvalid == m_rv && rresp == 2'b00, "R3 rvalid/rresp", {rresp, 1'b0, rvalid}, 64'(m_rv));
      chk(plain == m_pt && cipher == m_ct && start_key == m_sk, "R4 operand outputs",
          plain ^ m_pt ^ cipher ^ m_ct, 64'(start_key ^ m_sk));
      if (rvalid && m_rv) chk(rdata == m_rdata, "R3 rdata", 64'(rdata), 64'(m_rdata));
      if (irq) irq_cnt++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s, input int hold);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1; bready = (hold == 0);
    @(negedge clk);
    awvalid = 0;
    wvalid = (hold > 0); // probe: W alone must not be taken while B is pending
    for (int i = 0; i < hold; i++) begin
      chk(bvalid && !awready && !wready, "R2 write blocked during response", {awready, wready}, 64'h0);
      @(negedge clk);
    end
    wvalid = 0; bready = 1;
    @(negedge clk);
    bready = 0;
  endtask

  task automatic rd(input logic [7:0] a, input int hold, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1; rready = 0;
    @(negedge clk);
    arvalid = 0; d = rdata;
    for (int i = 0; i < hold; i++) @(negedge clk);
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    rd(a, 0, d);
    chk(d == e, tag, 64'(d), 64'(e));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errs++; vectors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin : main
    logic [31:0] lo, hi, d;
    logic [55:0] k;
    target = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!start && !stop && !irq && !bvalid && !rvalid && arready, "R1 outputs after reset",
        {start, stop, irq, bvalid, rvalid, arready}, 64'h1);
    for (int a = 0; a <= 8'h28; a += 4) rd_expect(8'(a), 32'h0, "R1 register reset value");

    // R4 readback and byte enables
    wr(8'h00, 32'h1122_3344, 4'hF, 0);
    wr(8'h04, 32'h5566_7788, 4'hF, 2);
    wr(8'h08, 32'h99AA_BBCC, 4'hF, 0);
    wr(8'h0C, 32'hDDEE_FF00, 4'hF, 1);
    rd_expect(8'h00, 32'h1122_3344, "R4 plaintext low");
    rd_expect(8'h0C, 32'hDDEE_FF00, "R4 ciphertext high");
    wr(8'h00, 32'hAABB_CCDD, 4'b0101, 0);
    rd_expect(8'h00, 32'h11BB_33DD, "R4 byte enables");
    wr(8'h08, 32'h0000_0000, 4'b0000, 0);
    rd_expect(8'h08, 32'h99AA_BBCC, "R4 empty strobe keeps word");

    // R5 key high word padding, R7 stop pulse (checked per clock)
    wr(8'h14, 32'hFFFF_FFFF, 4'hF, 0);
    rd_expect(8'h14, 32'h00FF_FFFF, "R5 key high bits 31:24 zero");

    // R10 unused, unaligned and read-only addresses
    wr(8'h20, 32'hDEAD_BEEF, 4'hF, 0);
    wr(8'h30, 32'hDEAD_BEEF, 4'hF, 0);
    wr(8'h11, 32'hDEAD_BEEF, 4'hF, 0);
    rd_expect(8'h20, 32'h0, "R10 read-only found key unchanged");
    rd_expect(8'h30, 32'h0, "R10 unused address reads zero");
    rd_expect(8'h02, 32'h0, "R10 unaligned address reads zero");
    rd_expect(8'h10, 32'h0, "R10 unaligned write ignored");

    // R6 launch a search just below a 32-bit carry, R8 split reads across it
    wr(8'h14, 32'h0000_0012, 4'hF, 0);
    wr(8'h10, 32'hFFFF_FFE8, 4'hF, 0);
    for (int n = 0; n < 14; n++) begin
      rd(8'h18, n % 3, lo);
      repeat (n % 4) @(negedge clk);
      rd(8'h1C, (n + 1) % 3, hi);
      k = {hi[23:0], lo};
      chk(hi[31:24] == 8'h0 && k >= 56'h12_FFFF_FFE8 && k < 56'h13_0000_0100,
          "R8 split read coherent", 64'(k), 64'h12_FFFF_FFE8);
    end
    rd(8'h1C, 0, hi);
    chk(hi[23:0] == 24'h13, "R8 tracking high read after carry", 64'(hi), 64'h13);

    // R7 halt and check progress stays still
    wr(8'h14, 32'h0000_0012, 4'hF, 0);
    rd(8'h18, 0, lo);
    rd(8'h1C, 0, hi);
    rd(8'h18, 0, d);
    chk(d == lo, "R7 stopped engine holds key", 64'(d), 64'(lo));

    // R9 match, interrupt, found key, status set and clear
    target = 56'h13_0000_0020;
    irq_cnt = 0;
    wr(8'h10, 32'hFFFF_FFF0, 4'hF, 0);
    for (int n = 0; n < 500 && irq_cnt == 0; n++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(irq_cnt == 1, "R9 single interrupt cycle", 64'(irq_cnt), 64'h1);
    rd_expect(8'h20, 32'h0000_0020, "R9 found key low");
    rd_expect(8'h24, 32'h0000_0013, "R9 found key high");
    rd_expect(8'h28, 32'h1, "R9 status set");
    target = '1;
    wr(8'h10, 32'h0000_0000, 4'hF, 0);
    rd_expect(8'h28, 32'h0, "R9 status cleared by start");
    wr(8'h14, 32'h0, 4'hF, 0);
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule